// File: doc/BRIEF.md
# DMA Channel Buffer-Chaining Engine

This block is one DMA channel that moves a programmed number of bytes between a source and a destination address, one beat at a time, through a simple request/acknowledge handshake with an external data mover. Software loads a working set (source, destination, count) and can also load a second, reload set. When the working count runs out, the channel signals count-to-zero. If a reload has been armed, the channel copies the reload set into the working set in that same event and carries on without going idle. This lets an interrupt handler keep a stream of buffers flowing. It does so by writing only the reload registers and re-arming them after each count-to-zero.

The channel is controlled through a small register port with a combinational read. The port uses eight word addresses:

| Address | Register |
|---|---|
| 0 | CTRL |
| 1 | SRC |
| 2 | DST |
| 3 | CNT |
| 4 | SRC_NEXT |
| 5 | DST_NEXT |
| 6 | CNT_NEXT |
| 7 | STATUS |

The state machine has three states:

- ST_IDLE: the channel is stopped.
- ST_MOVE: a beat request is outstanding.
- ST_SWAP: the count has reached zero and the channel decides whether to chain or stop.

The transitions are:

- ST_IDLE to ST_MOVE: a start with a nonzero count.
- ST_IDLE to ST_SWAP: a start with a zero count.
- ST_MOVE to ST_MOVE: an acknowledge while more than one beat remains.
- ST_MOVE to ST_SWAP: an acknowledge on the last beat.
- ST_MOVE to ST_IDLE: a bus error.
- ST_SWAP to ST_MOVE: the reload is armed and the reload count is nonzero.
- ST_SWAP to ST_SWAP: the reload is armed and the reload count is zero.
- ST_SWAP to ST_IDLE: no reload is armed.

Top module: `dma_chain_chan`

## Requirements
- R1: After reset every register reads as 0, `chan_busy` is 0 and `xfer_req` is 0.
- R2: A write to CTRL (address 0) with bit 0 set while the channel is idle starts it, and `chan_busy` reads 1 from the following cycle. Bit 1 set in that same write arms the reload. Bits 2 and 3 set source and destination increment. CTRL reads back bit 0 busy, bit 1 armed, bit 2 source increment and bit 3 destination increment.
- R3: In ST_MOVE, `xfer_req` stays high with stable addresses until `xfer_ack` or `xfer_err`. Each acknowledged beat decrements CNT (address 3) by one. It also advances SRC (address 1) and DST (address 2) by one when their increment bits are set.
- R4: When the working count reaches zero, `evt_ctz` pulses for one cycle and STATUS bit 1 becomes set.
- R5: If the reload is armed at count-to-zero, SRC, DST and CNT are loaded from SRC_NEXT, DST_NEXT and CNT_NEXT in the same cycle as `evt_ctz`. In that cycle `evt_reload` pulses, STATUS bit 2 sets, `chan_busy` stays 1 and the armed bit clears.
- R6: If no reload is armed at count-to-zero, `chan_busy` drops to 0 on the next cycle and no further requests are issued.
- R7: Writing CNT_NEXT (address 6) with bit 31 set arms the reload, also while the channel runs. Each arming yields exactly one further buffer.
- R8: `xfer_err` during a request stops the channel on the next cycle. It pulses `evt_buserr`, sets STATUS bit 3, clears the armed bit and leaves CNT untouched.
- R9: While the channel is busy, writes to SRC, DST, CNT and CTRL have no effect.
- R10: Writing 1 to STATUS (address 7) bits 1, 2 or 3 clears only those flags. STATUS bit 0 reads busy.
- R11: A start with a count of 0 performs no beats and raises count-to-zero at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address (read and write) |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_addr` |
| xfer_req | output | 1 | Beat request to the data mover |
| xfer_src | output | ADDR_W | Source address of the current beat |
| xfer_dst | output | ADDR_W | Destination address of the current beat |
| xfer_ack | input | 1 | Beat completed |
| xfer_err | input | 1 | Beat failed with a bus error |
| chan_busy | output | 1 | Channel running |
| evt_ctz | output | 1 | Count-to-zero event pulse |
| evt_reload | output | 1 | Reload-taken event pulse |
| evt_buserr | output | 1 | Bus-error event pulse |

## Verification
The hardest situation to reach is software arming a third buffer while the second is still in flight. The arming must land after the first reload has consumed the previous arm and before the second count-to-zero. The stimulus gets there by watching for the first count-to-zero pulse and then writing the three reload registers with the arm bit. Meanwhile the mover model stretches every beat with idle gaps, so the second buffer is long enough for the writes to land. A sweep over every small combination of first count, reload count, arming and increment modes also reaches back-to-back swaps, where a zero reload count makes ST_SWAP follow itself.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MOVE = 2'd1,
        ST_SWAP = 2'd2
    } chan_state_t;

    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] A_CTRL    = 3'd0;
    localparam logic [REG_AW-1:0] A_SRC     = 3'd1;
    localparam logic [REG_AW-1:0] A_DST     = 3'd2;
    localparam logic [REG_AW-1:0] A_CNT     = 3'd3;
    localparam logic [REG_AW-1:0] A_SRC_NX  = 3'd4;
    localparam logic [REG_AW-1:0] A_DST_NX  = 3'd5;
    localparam logic [REG_AW-1:0] A_CNT_NX  = 3'd6;
    localparam logic [REG_AW-1:0] A_STAT    = 3'd7;

    // CTRL bit positions
    localparam int B_RUN     = 0;
    localparam int B_ARM     = 1;
    localparam int B_SRC_INC = 2;
    localparam int B_DST_INC = 3;

    // STATUS bit positions
    localparam int B_BUSY = 0;
    localparam int B_CTZ  = 1;
    localparam int B_RLD  = 2;
    localparam int B_ERR  = 3;

endpackage

// File: rtl/dma_chain_regs.sv
module dma_chain_regs
    import dma_chain_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              busy,
    input  logic              beat,
    input  logic              do_reload,
    input  logic              ev_ctz,
    input  logic              ev_err,
    output logic              start,
    output logic [ADDR_W-1:0] src_q,
    output logic [ADDR_W-1:0] dst_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              nx_cnt_zero,
    output logic              armed_q
);

    localparam int ARM_BIT = DATA_W - 1;

    logic [ADDR_W-1:0] src_nx_q, dst_nx_q;
    logic [CNT_W-1:0]  cnt_nx_q;
    logic              src_inc_q, dst_inc_q;
    logic              fl_ctz_q, fl_rld_q, fl_err_q;
    logic              ctrl_wr_idle, arm_set, stat_wr;
    logic              unused_wdata;

    assign unused_wdata = ^wr_data;
    assign ctrl_wr_idle = wr_en && (reg_addr == A_CTRL) && !busy;
    assign start        = ctrl_wr_idle && wr_data[B_RUN];
    assign arm_set      = (wr_en && (reg_addr == A_CNT_NX) && wr_data[ARM_BIT])
                        || (start && wr_data[B_ARM]);
    assign stat_wr      = wr_en && (reg_addr == A_STAT);
    assign nx_cnt_zero  = (cnt_nx_q == '0);

    // working set: reload, beat update, or software write while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            dst_q <= '0;
            cnt_q <= '0;
        end else if (do_reload) begin
            src_q <= src_nx_q;
            dst_q <= dst_nx_q;
            cnt_q <= cnt_nx_q;
        end else if (beat) begin
            cnt_q <= cnt_q - 1'b1;
            if (src_inc_q) src_q <= src_q + 1'b1;
            if (dst_inc_q) dst_q <= dst_q + 1'b1;
        end else if (wr_en && !busy) begin
            case (reg_addr)
                A_SRC:   src_q <= wr_data[ADDR_W-1:0];
                A_DST:   dst_q <= wr_data[ADDR_W-1:0];
                A_CNT:   cnt_q <= wr_data[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    // reload set, writable at any time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_nx_q <= '0;
            dst_nx_q <= '0;
            cnt_nx_q <= '0;
        end else if (wr_en) begin
            case (reg_addr)
                A_SRC_NX: src_nx_q <= wr_data[ADDR_W-1:0];
                A_DST_NX: dst_nx_q <= wr_data[ADDR_W-1:0];
                A_CNT_NX: cnt_nx_q <= wr_data[CNT_W-1:0];
                default:  ;
            endcase
        end
    end

    // control bits and the single arm flag; a new arming beats consumption
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_inc_q <= 1'b0;
            dst_inc_q <= 1'b0;
            armed_q   <= 1'b0;
        end else begin
            if (ctrl_wr_idle) begin
                src_inc_q <= wr_data[B_SRC_INC];
                dst_inc_q <= wr_data[B_DST_INC];
            end
            if (arm_set)
                armed_q <= 1'b1;
            else if (do_reload || ev_err)
                armed_q <= 1'b0;
        end
    end

    // sticky status, set has priority over write-one-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fl_ctz_q <= 1'b0;
            fl_rld_q <= 1'b0;
            fl_err_q <= 1'b0;
        end else begin
            if (ev_ctz)                         fl_ctz_q <= 1'b1;
            else if (stat_wr && wr_data[B_CTZ]) fl_ctz_q <= 1'b0;
            if (do_reload)                      fl_rld_q <= 1'b1;
            else if (stat_wr && wr_data[B_RLD]) fl_rld_q <= 1'b0;
            if (ev_err)                         fl_err_q <= 1'b1;
            else if (stat_wr && wr_data[B_ERR]) fl_err_q <= 1'b0;
        end
    end

    always_comb begin
        rd_data = '0;
        case (reg_addr)
            A_CTRL: begin
                rd_data[B_RUN]     = busy;
                rd_data[B_ARM]     = armed_q;
                rd_data[B_SRC_INC] = src_inc_q;
                rd_data[B_DST_INC] = dst_inc_q;
            end
            A_SRC:    rd_data = DATA_W'(src_q);
            A_DST:    rd_data = DATA_W'(dst_q);
            A_CNT:    rd_data = DATA_W'(cnt_q);
            A_SRC_NX: rd_data = DATA_W'(src_nx_q);
            A_DST_NX: rd_data = DATA_W'(dst_nx_q);
            A_CNT_NX: begin
                rd_data          = DATA_W'(cnt_nx_q);
                rd_data[ARM_BIT] = armed_q;
            end
            default: begin
                rd_data[B_BUSY] = busy;
                rd_data[B_CTZ]  = fl_ctz_q;
                rd_data[B_RLD]  = fl_rld_q;
                rd_data[B_ERR]  = fl_err_q;
            end
        endcase
    end

endmodule

// File: rtl/dma_chain_fsm.sv
module dma_chain_fsm
    import dma_chain_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic cnt_zero,
    input  logic cnt_one,
    input  logic nx_cnt_zero,
    input  logic armed,
    input  logic xfer_ack,
    input  logic xfer_err,
    output logic busy,
    output logic xfer_req,
    output logic beat,
    output logic ev_ctz,
    output logic ev_rld,
    output logic ev_err
);

    chan_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = cnt_zero ? ST_SWAP : ST_MOVE;
            end
            ST_MOVE: begin
                if (xfer_err)                 state_d = ST_IDLE;
                else if (xfer_ack && cnt_one) state_d = ST_SWAP;
            end
            ST_SWAP: begin
                if (armed) state_d = nx_cnt_zero ? ST_SWAP : ST_MOVE;
                else       state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        busy     = (state_q != ST_IDLE);
        xfer_req = (state_q == ST_MOVE);
        beat     = (state_q == ST_MOVE) && xfer_ack && !xfer_err;
        ev_err   = (state_q == ST_MOVE) && xfer_err;
        ev_ctz   = (state_q == ST_SWAP);
        ev_rld   = (state_q == ST_SWAP) && armed;
    end

endmodule

// File: rtl/dma_chain_chan.sv
module dma_chain_chan
    import dma_chain_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              xfer_req,
    output logic [ADDR_W-1:0] xfer_src,
    output logic [ADDR_W-1:0] xfer_dst,
    input  logic              xfer_ack,
    input  logic              xfer_err,
    output logic              chan_busy,
    output logic              evt_ctz,
    output logic              evt_reload,
    output logic              evt_buserr
);

    logic              start, beat, nx_cnt_zero, armed_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] src_q, dst_q;
    logic              cnt_zero, cnt_one;

    assign cnt_zero = (cnt_q == '0);
    assign cnt_one  = (cnt_q == CNT_W'(1));
    assign xfer_src = src_q;
    assign xfer_dst = dst_q;

    dma_chain_regs #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_we),
        .reg_addr    (reg_addr),
        .wr_data     (reg_wdata),
        .rd_data     (reg_rdata),
        .busy        (chan_busy),
        .beat        (beat),
        .do_reload   (evt_reload),
        .ev_ctz      (evt_ctz),
        .ev_err      (evt_buserr),
        .start       (start),
        .src_q       (src_q),
        .dst_q       (dst_q),
        .cnt_q       (cnt_q),
        .nx_cnt_zero (nx_cnt_zero),
        .armed_q     (armed_q)
    );

    dma_chain_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .cnt_zero    (cnt_zero),
        .cnt_one     (cnt_one),
        .nx_cnt_zero (nx_cnt_zero),
        .armed       (armed_q),
        .xfer_ack    (xfer_ack),
        .xfer_err    (xfer_err),
        .busy        (chan_busy),
        .xfer_req    (xfer_req),
        .beat        (beat),
        .ev_ctz      (evt_ctz),
        .ev_rld      (evt_reload),
        .ev_err      (evt_buserr)
    );

endmodule

// File: rtl/dma_chain_chan_chk.sv
module dma_chain_chan_chk
    import dma_chain_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [2:0]        reg_addr,
    input logic              arm_wr,
    input logic              xfer_req,
    input logic              xfer_ack,
    input logic              xfer_err,
    input logic [ADDR_W-1:0] xfer_src,
    input logic [ADDR_W-1:0] xfer_dst,
    input logic              chan_busy,
    input logic              evt_ctz,
    input logic              evt_reload,
    input logic              evt_buserr,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              armed_q
);

    a_r3_req_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> chan_busy);

    a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_ack && !xfer_err) |=> ($stable(xfer_src) && $stable(xfer_dst)));

    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && xfer_ack && !xfer_err) |=> (cnt_q == $past(cnt_q) - 1'b1));

    a_r5_reload_with_ctz: assert property (@(posedge clk) disable iff (!rst_n)
        evt_reload |-> evt_ctz);

    a_r5_busy_kept: assert property (@(posedge clk) disable iff (!rst_n)
        evt_reload |=> chan_busy);

    a_r5_arm_consumed: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_reload && !(reg_we && reg_addr == A_CNT_NX && arm_wr)) |=> !armed_q);

    a_r6_stop_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_ctz && !evt_reload) |=> !chan_busy);

    a_r8_error_stops: assert property (@(posedge clk) disable iff (!rst_n)
        evt_buserr |=> (!chan_busy && !xfer_req));

    a_r9_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_busy && reg_we && reg_addr == A_CNT && !xfer_ack && !evt_reload)
        |=> $stable(cnt_q));

endmodule

bind dma_chain_chan dma_chain_chan_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .arm_wr     (reg_wdata[DATA_W-1]),
    .xfer_req   (xfer_req),
    .xfer_ack   (xfer_ack),
    .xfer_err   (xfer_err),
    .xfer_src   (xfer_src),
    .xfer_dst   (xfer_dst),
    .chan_busy  (chan_busy),
    .evt_ctz    (evt_ctz),
    .evt_reload (evt_reload),
    .evt_buserr (evt_buserr),
    .cnt_q      (cnt_q),
    .armed_q    (armed_q)
);

// File: tb/dma_chain_chan_tb.sv
module dma_chain_chan_tb;

    localparam int CLK_P  = 10;
    localparam int ADDR_W = 16;
    localparam int CNT_W  = 8;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_we = 1'b0;
    logic [2:0]        reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              xfer_req;
    logic [ADDR_W-1:0] xfer_src, xfer_dst;
    logic              xfer_ack = 1'b0;
    logic              xfer_err = 1'b0;
    logic              chan_busy, evt_ctz, evt_reload, evt_buserr;

    int n_chk = 0;
    int n_fail = 0;

    int gap_cfg = 0;
    int gap_ctr = 0;
    int err_at = -1;
    int resp_idx = 0;
    int beat_idx = 0;
    int evc_ctz = 0, evc_rld = 0, evc_err = 0;
    logic [ADDR_W-1:0] log_src [0:63];
    logic [ADDR_W-1:0] log_dst [0:63];

    always #(CLK_P/2) clk = ~clk;

    dma_chain_chan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_req(xfer_req),
        .xfer_src(xfer_src), .xfer_dst(xfer_dst), .xfer_ack(xfer_ack),
        .xfer_err(xfer_err), .chan_busy(chan_busy), .evt_ctz(evt_ctz),
        .evt_reload(evt_reload), .evt_buserr(evt_buserr)
    );

    task automatic chk(string tag, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // data mover model and event monitor
    initial begin
        forever begin
            @(negedge clk);
            if (xfer_ack || xfer_err) begin
                xfer_ack = 1'b0;
                xfer_err = 1'b0;
                gap_ctr  = gap_cfg;
            end else if (xfer_req) begin
                if (gap_ctr > 0) gap_ctr--;
                else begin
                    if (resp_idx == err_at) xfer_err = 1'b1;
                    else begin
                        xfer_ack = 1'b1;
                        if (beat_idx < 64) begin
                            log_src[beat_idx] = xfer_src;
                            log_dst[beat_idx] = xfer_dst;
                        end
                        beat_idx++;
                    end
                    resp_idx++;
                end
            end
            #(CLK_P/4);
            if (evt_ctz)    evc_ctz++;
            if (evt_reload) evc_rld++;
            if (evt_buserr) evc_err++;
        end
    end

    initial begin
        #(CLK_P * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
        summary();
    end

    task automatic wr(logic [2:0] a, logic [DATA_W-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [DATA_W-1:0] d);
        @(negedge clk);
        reg_addr = a;
        #(CLK_P/4);
        d = reg_rdata;
    endtask

    task automatic clear_counts(int gap);
        gap_cfg = gap; gap_ctr = gap;
        resp_idx = 0; beat_idx = 0;
        evc_ctz = 0; evc_rld = 0; evc_err = 0;
    endtask

    task automatic wait_idle();
        while (chan_busy) @(negedge clk);
    endtask

    // one run of up to two buffers, all expectations computed here
    task automatic run_pair(int c1, int c2, bit arm, bit si, bit di, int gap);
        logic [DATA_W-1:0] rv;
        int total, mism, exp_src;
        logic [ADDR_W-1:0] s1, d1, s2, d2;
        s1 = 16'h0100; d1 = 16'h2000; s2 = 16'h0400; d2 = 16'h3000;
        wr(3'd1, DATA_W'(s1)); wr(3'd2, DATA_W'(d1)); wr(3'd3, DATA_W'(c1));
        wr(3'd4, DATA_W'(s2)); wr(3'd5, DATA_W'(d2)); wr(3'd6, DATA_W'(c2));
        clear_counts(gap);
        wr(3'd0, DATA_W'({di, si, arm, 1'b1}));
        chk("R2 busy after start", chan_busy, 1);
        wait_idle();
        total = c1 + (arm ? c2 : 0);
        chk("R3 beat count", beat_idx, total);
        chk(c1 == 0 ? "R11 ctz events" : "R4 ctz events", evc_ctz, arm ? 2 : 1);
        chk("R5 reload events", evc_rld, arm ? 1 : 0);
        mism = 0;
        for (int k = 0; k < total; k++) begin
            int off;
            logic [ADDR_W-1:0] bs, bd;
            off = (k < c1) ? k : k - c1;
            bs  = (k < c1) ? s1 : s2;
            bd  = (k < c1) ? d1 : d2;
            if (log_src[k] != bs + ADDR_W'(si ? off : 0)) mism++;
            if (log_dst[k] != bd + ADDR_W'(di ? off : 0)) mism++;
        end
        chk("R3 beat addresses", mism, 0);
        rd(3'd1, rv);
        exp_src = arm ? (s2 + (si ? c2 : 0)) : (s1 + (si ? c1 : 0));
        chk("R5 final SRC", rv, exp_src);
        rd(3'd3, rv);
        chk("R3 final CNT", rv, 0);
        rd(3'd0, rv);
        chk("R5 arm consumed", rv[1], 0);
        chk("R6 no request after stop", xfer_req, 0);
        rd(3'd7, rv);
        chk("R4 status ctz", rv[1], 1);
        chk("R5 status reload", rv[2], arm ? 1 : 0);
        wr(3'd7, 32'hE);
    endtask

    initial begin
        logic [DATA_W-1:0] rv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), rv);
            chk("R1 register reset", rv, 0);
        end
        chk("R1 busy reset", chan_busy, 0);
        chk("R1 req reset", xfer_req, 0);

        // sweep of small counts, arming and increment modes
        for (int c1 = 0; c1 < 4; c1++)
            for (int c2 = 0; c2 < 4; c2++)
                for (int m = 0; m < 8; m++)
                    run_pair(c1, c2, m[0], m[1], m[2], (c1 + c2) % 3);

        // R7: handler arms a third buffer after the first count-to-zero
        wr(3'd1, 32'h0010); wr(3'd2, 32'h0800); wr(3'd3, 32'd2);
        wr(3'd4, 32'h0020); wr(3'd5, 32'h0900); wr(3'd6, 32'd3);
        clear_counts(2);
        wr(3'd0, 32'hF);
        wait (evc_ctz >= 1);
        wr(3'd4, 32'h0030); wr(3'd5, 32'h0A00);
        wr(3'd6, 32'h8000_0002);
        wait_idle();
        chk("R7 chained beats", beat_idx, 7);
        chk("R7 ctz events", evc_ctz, 3);
        chk("R7 reload events", evc_rld, 2);
        chk("R7 third buffer src", log_src[6], 16'h0031);
        chk("R7 third buffer dst", log_dst[5], 16'h0A00);

        // R10: write-one-to-clear per flag
        wr(3'd7, 32'h2);
        rd(3'd7, rv);
        chk("R10 ctz cleared", rv[1], 0);
        chk("R10 reload kept", rv[2], 1);
        wr(3'd7, 32'h4);
        rd(3'd7, rv);
        chk("R10 all clear", rv, 0);

        // R8: bus error on the third response
        wr(3'd1, 32'h0040); wr(3'd2, 32'h0B00); wr(3'd3, 32'd4);
        wr(3'd6, 32'd2);
        clear_counts(1);
        err_at = 2;
        wr(3'd0, 32'hF);
        wait_idle();
        err_at = -1;
        chk("R8 beats before error", beat_idx, 2);
        chk("R8 error events", evc_err, 1);
        chk("R8 no ctz", evc_ctz, 0);
        rd(3'd3, rv);
        chk("R8 count untouched", rv, 2);
        rd(3'd7, rv);
        chk("R8 status error", rv[3], 1);
        rd(3'd0, rv);
        chk("R8 arm cleared", rv[1], 0);
        repeat (4) @(negedge clk);
        chk("R8 no request", xfer_req, 0);
        wr(3'd7, 32'hE);

        // R9: working registers and CTRL are frozen while busy
        wr(3'd1, 32'h0050); wr(3'd2, 32'h0C00); wr(3'd3, 32'd3);
        wr(3'd6, 32'd5);
        clear_counts(4);
        wr(3'd0, 32'hD);
        wr(3'd1, 32'h0777); wr(3'd2, 32'h0555); wr(3'd3, 32'd40);
        wr(3'd0, 32'h3);
        wait_idle();
        chk("R9 beats", beat_idx, 3);
        chk("R9 no reload", evc_rld, 0);
        chk("R9 last src", log_src[2], 16'h0052);
        rd(3'd1, rv);
        chk("R9 SRC kept", rv, 32'h0053);
        rd(3'd2, rv);
        chk("R9 DST kept", rv, 32'h0C03);
        rd(3'd0, rv);
        chk("R9 CTRL write ignored", rv[1], 0);

        summary();
    end

endmodule